// File: doc/BRIEF.md
# Mode-Selected Interrupt Flag Poller

This block gathers eleven interrupt request flags for a small controller core: five general-purpose sources, four sources from a serial channel (receive valid, receive error, transmit valid, transmit error) and a completion flag from each of two DMA channels. A machine-cycle phase strobe marks the single clock in each machine cycle at which the flags are captured. The captured copies are resolved during the machine cycle that follows. The winning source index and its vector address are registered onto the outputs at the next strobe.

For the two serial "valid" sources, a DMA-mode input picks the source of the request. When the channel is serviced by software, the request comes from a FIFO-level flag. When DMA moves the data, it comes from an operation-done flag. Each error request is the OR of a bundle of error condition lines. Each source has an enable bit and a priority bit, and a global enable gates everything. Once a request is presented, it stays on the outputs until the CPU acknowledges it.

Top module: `intr_poller`

## Requirements
- R1: After reset, `irq` is 0, `vec` is 0 and `src_id` is 0.
- R2: With `dma_mode` = 0, source 5 (receive valid) requests from `rx_fifo_ne` and source 7 (transmit valid) requests from `tx_fifo_nf`. `rx_done` and `tx_done` have no effect in this mode.
- R3: With `dma_mode` = 1, source 5 requests from `rx_done` and source 7 requests from `tx_done`. `rx_fifo_ne` and `tx_fifo_nf` have no effect in this mode.
- R4: Source 6 requests when any bit of `rx_err` is 1, and source 8 requests when any bit of `tx_err` is 1.
- R5: Flags are captured only at a clock edge where `mc_sample` is 1. A capture at one strobe appears on `irq`/`vec`/`src_id` at the following strobe edge, and never earlier. Outside strobe edges, `irq` never rises and `vec`/`src_id` never change.
- R6: A flag that rises and falls entirely between two strobe edges produces no request.
- R7: Among enabled requests of equal priority, the lowest source index wins. The index order is: general sources 0 to 4 on `gen_flag[0..4]`, then 5 receive valid, 6 receive error, 7 transmit valid, 8 transmit error, 9 DMA channel 0 done, 10 DMA channel 1 done.
- R8: An enabled request whose `src_pri` bit is 1 beats every request whose bit is 0, whatever its index.
- R9: A source whose `src_en` bit is 0, or any source while `glob_en` is 0, never wins. When no enabled request was captured, the strobe loads `irq` = 0, `vec` = 0 and `src_id` = 0.
- R10: While `irq` is 1, `vec` equals VEC_BASE + VEC_STEP × `src_id`. With the defaults (3 and 8) this gives 0x03, 0x0B, … 0x53.
- R11: While `irq` is 1 and `ack` is 0, `irq`, `vec` and `src_id` hold, including across strobes. `ack` without a strobe clears `irq` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_sample | input | 1 | Machine-cycle sampling strobe, one clock wide |
| gen_flag | input | 5 | General-purpose request flags, sources 0..4 |
| rx_fifo_ne | input | 1 | Receive FIFO holds data |
| rx_done | input | 1 | Receive operation complete |
| tx_fifo_nf | input | 1 | Transmit FIFO has room |
| tx_done | input | 1 | Transmit operation complete |
| rx_err | input | RXE_W | Receive error condition lines |
| tx_err | input | TXE_W | Transmit error condition lines |
| dma0_done | input | 1 | DMA channel 0 finished |
| dma1_done | input | 1 | DMA channel 1 finished |
| dma_mode | input | 1 | 1: valid sources use done flags; 0: FIFO flags |
| glob_en | input | 1 | Global interrupt enable |
| src_en | input | 11 | Per-source enable, bit = source index |
| src_pri | input | 11 | Per-source priority (1 = high), bit = source index |
| ack | input | 1 | CPU acknowledge of the presented request |
| irq | output | 1 | Interrupt request to the CPU |
| vec | output | VEC_W | Vector address of the winning source |
| src_id | output | 4 | Index of the winning source |

## Verification
A wrong captured flag set, or a wrong mode selection in the receive or transmit path, shows up as a wrong or missing `src_id` at the second strobe after the stimulus, which is one machine cycle after the capture. A corrupted winner choice in the arbiter shows up at that same strobe as a wrong index or a wrong vector. A broken hold register shows up as an output that moves between strobes or while unacknowledged. Such a fault is visible within one clock of the edge where it occurs.

// File: rtl/intr_poll_pkg.sv
package intr_poll_pkg;

    localparam int NUM_SRC = 11;
    localparam int ID_W    = 4;
    localparam int NUM_GEN = 5;

    // polling order: lower index is polled first
    localparam int SRC_GEN0 = 0;
    localparam int SRC_RXV  = 5;
    localparam int SRC_RXE  = 6;
    localparam int SRC_TXV  = 7;
    localparam int SRC_TXE  = 8;
    localparam int SRC_DMA0 = 9;
    localparam int SRC_DMA1 = 10;

    typedef struct packed {
        logic            hit;
        logic [ID_W-1:0] id;
    } win_t;

endpackage

// File: rtl/ip_flag_select.sv
module ip_flag_select
    import intr_poll_pkg::*;
#(
    parameter int RXE_W = 3,
    parameter int TXE_W = 3
) (
    input  logic [NUM_GEN-1:0] gen_flag,
    input  logic               rx_fifo_ne,
    input  logic               rx_done,
    input  logic               tx_fifo_nf,
    input  logic               tx_done,
    input  logic [RXE_W-1:0]   rx_err,
    input  logic [TXE_W-1:0]   tx_err,
    input  logic               dma0_done,
    input  logic               dma1_done,
    input  logic               dma_mode,
    output logic [NUM_SRC-1:0] req_raw
);

    logic rxv, txv;

    // valid sources: FIFO level in software mode, done flag in DMA mode
    always_comb begin
        rxv = dma_mode ? rx_done : rx_fifo_ne;
        txv = dma_mode ? tx_done : tx_fifo_nf;
    end

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        assign req_raw[SRC_GEN0 + g] = gen_flag[g];
    end

    assign req_raw[SRC_RXV]  = rxv;
    assign req_raw[SRC_RXE]  = |rx_err;
    assign req_raw[SRC_TXV]  = txv;
    assign req_raw[SRC_TXE]  = |tx_err;
    assign req_raw[SRC_DMA0] = dma0_done;
    assign req_raw[SRC_DMA1] = dma1_done;

endmodule

// File: rtl/ip_sample_stage.sv
module ip_sample_stage
    import intr_poll_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mc_sample,
    input  logic [NUM_SRC-1:0] req_raw,
    output logic [NUM_SRC-1:0] req_smp
);

    typedef struct packed {
        logic [NUM_SRC-1:0] flags;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        if (mc_sample) begin
            smp_d.flags = req_raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign req_smp = smp_q.flags;

endmodule

// File: rtl/ip_poll_arbiter.sv
module ip_poll_arbiter
    import intr_poll_pkg::*;
(
    input  logic [NUM_SRC-1:0] req_smp,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] src_pri,
    input  logic               glob_en,
    output win_t               win
);

    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] hi_live;
    logic [NUM_SRC-1:0] cand;

    always_comb begin
        live    = req_smp & src_en & {NUM_SRC{glob_en}};
        hi_live = live & src_pri;
        // high level pre-empts the whole low level
        cand    = (|hi_live) ? hi_live : live;
        win.hit = |cand;
        win.id  = '0;
        // scan from the back so the lowest set index ends up in win.id
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                win.id = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/ip_vector_hold.sv
module ip_vector_hold
    import intr_poll_pkg::*;
#(
    parameter int          VEC_W    = 16,
    parameter int unsigned VEC_BASE = 3,
    parameter int unsigned VEC_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_sample,
    input  logic             ack,
    input  win_t             win,
    output logic             irq,
    output logic [VEC_W-1:0] vec,
    output logic [ID_W-1:0]  src_id
);

    typedef struct packed {
        logic             irq;
        logic [ID_W-1:0]  id;
        logic [VEC_W-1:0] vec;
    } hold_t;

    hold_t hold_d, hold_q;
    logic  free;

    always_comb begin
        hold_d = hold_q;
        free   = !hold_q.irq || ack;
        if (mc_sample && free) begin
            hold_d.irq = win.hit;
            hold_d.id  = win.hit ? win.id : '0;
            hold_d.vec = win.hit ? (VEC_W'(VEC_BASE) + VEC_W'(win.id) * VEC_W'(VEC_STEP))
                                 : '0;
        end else if (ack) begin
            hold_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign irq    = hold_q.irq;
    assign vec    = hold_q.vec;
    assign src_id = hold_q.id;

endmodule

// File: rtl/intr_poller.sv
module intr_poller
    import intr_poll_pkg::*;
#(
    parameter int          RXE_W    = 3,
    parameter int          TXE_W    = 3,
    parameter int          VEC_W    = 16,
    parameter int unsigned VEC_BASE = 3,
    parameter int unsigned VEC_STEP = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mc_sample,
    input  logic [4:0]         gen_flag,
    input  logic               rx_fifo_ne,
    input  logic               rx_done,
    input  logic               tx_fifo_nf,
    input  logic               tx_done,
    input  logic [RXE_W-1:0]   rx_err,
    input  logic [TXE_W-1:0]   tx_err,
    input  logic               dma0_done,
    input  logic               dma1_done,
    input  logic               dma_mode,
    input  logic               glob_en,
    input  logic [10:0]        src_en,
    input  logic [10:0]        src_pri,
    input  logic               ack,
    output logic               irq,
    output logic [VEC_W-1:0]   vec,
    output logic [3:0]         src_id
);

    logic [NUM_SRC-1:0] req_raw;
    logic [NUM_SRC-1:0] req_smp;
    win_t               win;

    ip_flag_select #(.RXE_W(RXE_W), .TXE_W(TXE_W)) u_sel (
        .gen_flag   (gen_flag),
        .rx_fifo_ne (rx_fifo_ne),
        .rx_done    (rx_done),
        .tx_fifo_nf (tx_fifo_nf),
        .tx_done    (tx_done),
        .rx_err     (rx_err),
        .tx_err     (tx_err),
        .dma0_done  (dma0_done),
        .dma1_done  (dma1_done),
        .dma_mode   (dma_mode),
        .req_raw    (req_raw)
    );

    ip_sample_stage u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .mc_sample (mc_sample),
        .req_raw   (req_raw),
        .req_smp   (req_smp)
    );

    ip_poll_arbiter u_arb (
        .req_smp (req_smp),
        .src_en  (src_en),
        .src_pri (src_pri),
        .glob_en (glob_en),
        .win     (win)
    );

    ip_vector_hold #(
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .mc_sample (mc_sample),
        .ack       (ack),
        .win       (win),
        .irq       (irq),
        .vec       (vec),
        .src_id    (src_id)
    );

endmodule

// File: rtl/intr_poller_chk.sv
module intr_poller_chk #(
    parameter int          VEC_W    = 16,
    parameter int unsigned VEC_BASE = 3,
    parameter int unsigned VEC_STEP = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mc_sample,
    input logic             ack,
    input logic             irq,
    input logic [VEC_W-1:0] vec,
    input logic [3:0]       src_id
);

    assert_quiet_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_sample |=> ($stable(vec) && $stable(src_id) && !$rose(irq)));

    assert_id_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (src_id < 4'd11));

    assert_vec_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vec == VEC_W'(VEC_BASE) + VEC_W'(src_id) * VEC_W'(VEC_STEP)));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> (irq && $stable(vec) && $stable(src_id)));

    assert_ack_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack && !mc_sample) |=> !irq);

endmodule

bind intr_poller intr_poller_chk #(
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mc_sample (mc_sample),
    .ack       (ack),
    .irq       (irq),
    .vec       (vec),
    .src_id    (src_id)
);

// File: tb/sim_intr_poller.sv
module sim_intr_poller;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_sample = 1'b0;
    logic [4:0]  gen_flag = '0;
    logic        rx_fifo_ne = 1'b0, rx_done = 1'b0, tx_fifo_nf = 1'b0, tx_done = 1'b0;
    logic [2:0]  rx_err = '0, tx_err = '0;
    logic        dma0_done = 1'b0, dma1_done = 1'b0, dma_mode = 1'b0;
    logic        glob_en = 1'b1;
    logic [10:0] src_en = '1, src_pri = '0;
    logic        ack = 1'b0;
    logic        irq;
    logic [15:0] vec;
    logic [3:0]  src_id;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef struct {
        string       tag;
        logic        irq;
        logic [3:0]  id;
        logic [15:0] vec;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    intr_poller u0 (
        .clk(clk), .rst_n(rst_n), .mc_sample(mc_sample), .gen_flag(gen_flag),
        .rx_fifo_ne(rx_fifo_ne), .rx_done(rx_done), .tx_fifo_nf(tx_fifo_nf),
        .tx_done(tx_done), .rx_err(rx_err), .tx_err(tx_err),
        .dma0_done(dma0_done), .dma1_done(dma1_done), .dma_mode(dma_mode),
        .glob_en(glob_en), .src_en(src_en), .src_pri(src_pri), .ack(ack),
        .irq(irq), .vec(vec), .src_id(src_id)
    );

    task automatic check(string tag, logic e_irq, logic [3:0] e_id, logic [15:0] e_vec);
        n_chk++;
        if (irq !== e_irq || src_id !== e_id || vec !== e_vec) begin
            n_err++;
            $display("FAIL %s: got irq=%0b id=%0d vec=%h, expected irq=%0b id=%0d vec=%h",
                     tag, irq, src_id, vec, e_irq, e_id, e_vec);
        end
    endtask

    task automatic check_irq(string tag, logic e_irq);
        n_chk++;
        if (irq !== e_irq) begin
            n_err++;
            $display("FAIL %s: got irq=%0b, expected irq=%0b", tag, irq, e_irq);
        end
    endtask

    // expected winner for the next loading strobe; -1 means none
    task automatic expect_id(string tag, int id);
        item_t it;
        it.tag = tag;
        if (id < 0) begin
            it.irq = 1'b0; it.id = '0; it.vec = '0;
        end else begin
            it.irq = 1'b1; it.id = 4'(id); it.vec = 16'(3 + 8 * id);
        end
        sb.push_back(it);
    endtask

    // monitor: compares one queued item after each strobe edge
    always @(posedge clk) begin
        if (mc_sample && rst_n) begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, it.irq, it.id, it.vec);
            end
        end
    end

    task automatic strobe();
        @(negedge clk) mc_sample = 1'b1;
        @(negedge clk) mc_sample = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
    endtask

    task automatic zero_flags();
        gen_flag = '0; rx_fifo_ne = 0; rx_done = 0; tx_fifo_nf = 0; tx_done = 0;
        rx_err = '0; tx_err = '0; dma0_done = 0; dma1_done = 0;
    endtask

    // empty the capture register and the outputs
    task automatic clean();
        zero_flags();
        strobe(); pulse_ack();
        strobe(); pulse_ack();
        dma_mode = 0; glob_en = 1; src_en = '1; src_pri = '0;
    endtask

    // capture the present flags, then load them at the next strobe
    task automatic run(string tag, int id);
        strobe();
        expect_id(tag, id);
        strobe();
        clean();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0, 4'd0, 16'h0000);
        rst_n = 1'b1;
        clean();

        // R5 latency: nothing before the second strobe
        gen_flag[2] = 1;
        strobe();
        check_irq("R5 no output after capture strobe", 1'b0);
        expect_id("R5 R10 gen2 after load strobe", 2);
        strobe();
        clean();

        gen_flag = 5'b10001;               run("R7 gen0 beats gen4", 0);
        gen_flag = '1; rx_fifo_ne = 1; rx_err = 3'b001; tx_fifo_nf = 1; tx_err = 3'b100;
        dma0_done = 1; dma1_done = 1;      run("R7 all sources, gen0 wins", 0);

        rx_fifo_ne = 1;                    run("R2 rx fifo in mode 0", 5);
        rx_done = 1;                       run("R2 rx done ignored in mode 0", -1);
        tx_fifo_nf = 1;                    run("R2 tx fifo in mode 0", 7);
        tx_done = 1;                       run("R2 tx done ignored in mode 0", -1);
        dma_mode = 1; rx_done = 1;         run("R3 rx done in mode 1", 5);
        dma_mode = 1; rx_fifo_ne = 1;      run("R3 rx fifo ignored in mode 1", -1);
        dma_mode = 1; tx_done = 1;         run("R3 tx done in mode 1", 7);
        dma_mode = 1; tx_fifo_nf = 1;      run("R3 tx fifo ignored in mode 1", -1);

        rx_err = 3'b100;                   run("R4 rx error bit2", 6);
        tx_err = 3'b001;                   run("R4 tx error bit0", 8);
        tx_err = 3'b110; dma0_done = 1;    run("R4 tx error multi beats dma0", 8);

        dma0_done = 1; dma1_done = 1;      run("R7 R10 dma0 over dma1", 9);
        dma1_done = 1;                     run("R10 dma1 vector", 10);

        gen_flag[0] = 1; dma1_done = 1; src_pri[10] = 1;
                                           run("R8 high dma1 beats low gen0", 10);
        gen_flag = 5'b01001; dma0_done = 1; src_pri[3] = 1; src_pri[9] = 1;
                                           run("R8 R7 two high, lower index wins", 3);

        gen_flag = 5'b10001; src_en[0] = 0; run("R9 disabled gen0 skipped", 4);
        gen_flag[1] = 1; rx_err = 3'b010; src_en[1] = 0; src_pri[1] = 1;
                                           run("R9 disabled high loses to low", 6);
        gen_flag = '1; glob_en = 0;        run("R9 global disable", -1);

        // R6: short pulse between strobes is lost
        @(negedge clk) gen_flag[1] = 1;
        repeat (2) @(negedge clk);
        gen_flag[1] = 0;
        run("R6 pulse between strobes", -1);

        // R11: hold until acknowledge
        gen_flag[2] = 1;
        strobe(); strobe();
        check("R11 presented gen2", 1'b1, 4'd2, 16'h0013);
        gen_flag = 5'b00001;
        strobe(); strobe();
        check("R11 held across strobes", 1'b1, 4'd2, 16'h0013);
        pulse_ack();
        check_irq("R11 ack clears irq", 1'b0);
        expect_id("R11 next strobe loads gen0", 0);
        strobe();
        clean();

        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule